// File: doc/BRIEF.md
# Multithreaded Thread Issue Selector

This block decides, every clock, which of the hardware thread contexts of a small in-order multithreaded core may place instructions into the four execution slots. There are two ALU slots, one memory slot and one branch slot. Each thread presents its remaining stall length and a short window of the classes of its next instructions, oldest first. The selector returns a registered slot-to-thread grant map, plus a drain flag that tells the pipeline to empty itself after a coarse-grained thread switch.

Three policies share one arbiter. The rotating policy moves to a different thread every cycle and passes over stalled threads. The stall-switch policy keeps one thread until it hits a long stall, then switches and imposes a refill penalty. The shared-slot policy lets several threads issue in the same cycle, filling typed slots in a fixed preference order.

Top module: `thread_issue_sel`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every slot is invalid, every slot thread id reads 0 and `drain_o` is low. The thread pointer resets to thread 2, so the first rotating pick is thread 0.
- R2: Mode codes: 0 and 3 are rotating, 1 is stall-switch and 2 is shared-slot. In rotating mode the granted thread is the first thread after the previous pick, in circular order, whose stall length is 0. Only that thread's instructions are granted in that cycle.
- R3: In rotating mode, when every thread is stalled, no slot is granted and the pointer is held, so the next pick continues from the same place.
- R4: In stall-switch mode the current thread issues whenever its stall length is 0. A stall of 1 or 2 cycles grants nothing and keeps the same thread.
- R5: In stall-switch mode a stall longer than 2 cycles moves the current thread to the next unstalled thread in circular order. `drain_o` is then high for REFILL (default 5) consecutive cycles with no grants. If no other thread is free, nothing is granted and no switch happens.
- R6: Slot layout: slots 0 and 1 take ALU instructions, filled in order. Slot 2 takes memory instructions and slot 3 takes branch instructions. An invalid slot reports thread id 0. Output `slot_tid_o` holds slot s at bits [2s+1:2s].
- R7: In shared-slot mode, thread 0 claims slots first, then thread 1, then thread 2. Stalled threads take part in no mode.
- R8: Class codes are 0 none, 1 ALU, 2 memory and 3 branch. Window entry k of thread t sits at bits [2(4t+k)+1 : 2(4t+k)], with k=0 the oldest. A thread's instructions are granted in order, and it receives nothing more in that cycle after its first instruction that finds no free slot of its class, or after its first none code.
- R9: While a refill penalty runs, the mode input and the request inputs have no effect. A new mode applies only once the drain has ended.
- R10: `stall_len_i` holds thread t's remaining stall cycles at bits [4t+3:4t]. Outputs are registered and reflect the inputs of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Policy select |
| stall_len_i | input | 12 | Remaining stall cycles per thread |
| req_cls_i | input | 24 | Per-thread window of next instruction classes |
| slot_vld_o | output | 4 | Slot granted this cycle |
| slot_tid_o | output | 8 | Thread owning each slot |
| drain_o | output | 1 | Pipeline drain/refill in progress |

## Verification
The collision that matters is between a stall-switch refill and a mode change: a change requested while the drain counter is running must not cut the penalty short or leak grants. The bench triggers a long stall in stall-switch mode and then moves the mode to shared-slot in the very next cycle. A reference model that holds the mode until the drain ends predicts REFILL drain cycles with an empty grant map, followed by shared-slot packing. Random runs also mix mode flips with long stalls, so the two events overlap many more times.

// File: rtl/tis_pkg.sv
package tis_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_ALU  = 2'd1,
    CLS_MEM  = 2'd2,
    CLS_BR   = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    MD_ROTATE  = 2'd0,
    MD_STALLSW = 2'd1,
    MD_SHARED  = 2'd2,
    MD_ROT_ALT = 2'd3
  } mode_e;
endpackage

// File: rtl/thread_rotator.sv
module thread_rotator #(
  parameter int NTHR = 3,
  parameter int TW   = 2
) (
  input  logic [TW-1:0]   base,
  input  logic [NTHR-1:0] ready,
  output logic            found,
  output logic [TW-1:0]   pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 1; i <= NTHR; i++) begin
      int j;
      j = (int'(base) + i) % NTHR;
      if (!found && ready[j]) begin
        found = 1'b1;
        pick  = TW'(j);
      end
    end
  end
endmodule

// File: rtl/slot_packer.sv
module slot_packer import tis_pkg::*; #(
  parameter int NTHR  = 3,
  parameter int TW    = 2,
  parameter int LOOK  = 4,
  parameter int N_ALU = 2,
  parameter int N_MEM = 1,
  parameter int N_BR  = 1,
  localparam int NSLOT = N_ALU + N_MEM + N_BR
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NTHR-1:0]       en,
  input  logic [NTHR*LOOK*2-1:0] req,
  output logic [NSLOT-1:0]      vld,
  output logic [NSLOT*TW-1:0]   tid
);
  always_comb begin
    int alu_n, mem_n, br_n;
    alu_n = 0;
    mem_n = 0;
    br_n  = 0;
    vld   = '0;
    tid   = '0;
    // threads visited in preference order, lowest index first
    for (int t = 0; t < NTHR; t++) begin
      logic blk;
      blk = !en[t];
      for (int k = 0; k < LOOK; k++) begin
        cls_e c;
        int   s;
        c = cls_e'(req[(t*LOOK+k)*2 +: 2]);
        s = -1;
        if (!blk) begin
          case (c)
            CLS_ALU: if (alu_n < N_ALU) begin s = alu_n;               alu_n++; end
            CLS_MEM: if (mem_n < N_MEM) begin s = N_ALU + mem_n;       mem_n++; end
            CLS_BR:  if (br_n  < N_BR)  begin s = N_ALU + N_MEM + br_n; br_n++; end
            default: s = -1;
          endcase
          if (s < 0) blk = 1'b1;
          else begin
            vld[s]         = 1'b1;
            tid[s*TW +: TW] = TW'(t);
          end
        end
      end
    end
  end

  // ALU slots are filled from the lowest index upward (R6)
  p_alu_fill_order_r6: assert property (@(posedge clk) disable iff (rst)
    (N_ALU > 1 && vld[1]) |-> vld[0]);
endmodule

// File: rtl/refill_timer.sv
module refill_timer #(
  parameter int REFILL = 5,
  localparam int RW = $clog2(REFILL + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= RW'(REFILL - 1);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // a new switch is never started while a penalty is still running (R5)
  p_load_idle_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> !load);
endmodule

// File: rtl/thread_issue_sel.sv
module thread_issue_sel import tis_pkg::*; #(
  parameter int NTHR       = 3,
  parameter int N_ALU      = 2,
  parameter int N_MEM      = 1,
  parameter int N_BR       = 1,
  parameter int LOOK       = 4,
  parameter int SW         = 4,
  parameter int SWITCH_MIN = 2,
  parameter int REFILL     = 5,
  localparam int NSLOT = N_ALU + N_MEM + N_BR,
  localparam int TW    = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              mode_i,
  input  logic [NTHR*SW-1:0]      stall_len_i,
  input  logic [NTHR*LOOK*2-1:0]  req_cls_i,
  output logic [NSLOT-1:0]        slot_vld_o,
  output logic [NSLOT*TW-1:0]     slot_tid_o,
  output logic                    drain_o
);
  logic [NTHR-1:0] ready, longst, en;
  logic [TW-1:0]   cur_q, cur_d, nxt;
  logic            nxt_ok, draining, ld, drain_d;
  logic [NSLOT-1:0]    pk_vld;
  logic [NSLOT*TW-1:0] pk_tid;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign ready[t]  = (stall_len_i[t*SW +: SW] == '0);
    assign longst[t] = (int'(stall_len_i[t*SW +: SW]) > SWITCH_MIN);
  end

  thread_rotator #(.NTHR(NTHR), .TW(TW)) u_rot (
    .base(cur_q), .ready(ready), .found(nxt_ok), .pick(nxt));

  refill_timer #(.REFILL(REFILL)) u_tmr (
    .clk(clk), .rst(rst), .load(ld), .busy(draining));

  slot_packer #(.NTHR(NTHR), .TW(TW), .LOOK(LOOK),
                .N_ALU(N_ALU), .N_MEM(N_MEM), .N_BR(N_BR)) u_pack (
    .clk(clk), .rst(rst), .en(en), .req(req_cls_i), .vld(pk_vld), .tid(pk_tid));

  always_comb begin
    en      = '0;
    cur_d   = cur_q;
    ld      = 1'b0;
    drain_d = draining;
    if (!draining) begin
      case (mode_e'(mode_i))
        MD_STALLSW: begin
          if (ready[cur_q]) en[cur_q] = 1'b1;
          else if (longst[cur_q] && nxt_ok) begin
            cur_d   = nxt;
            ld      = 1'b1;
            drain_d = 1'b1;
          end
        end
        MD_SHARED: en = ready;
        default: begin
          if (nxt_ok) begin
            en[nxt] = 1'b1;
            cur_d   = nxt;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld_o <= '0;
      slot_tid_o <= '0;
      drain_o    <= 1'b0;
      cur_q      <= TW'(NTHR - 1);
    end else begin
      slot_vld_o <= pk_vld;
      slot_tid_o <= pk_tid;
      drain_o    <= drain_d;
      cur_q      <= cur_d;
    end
  end

  // grant map and drain flag are mutually exclusive (R5)
  p_drain_no_grant_r5: assert property (@(posedge clk) disable iff (rst)
    drain_o |-> (slot_vld_o == '0));

  // while a penalty runs, mode and requests are ignored (R9)
  p_drain_hold_r9: assert property (@(posedge clk) disable iff (rst)
    draining |-> (pk_vld == '0 && cur_d == cur_q));

  // a stalled thread never owns a slot (R7)
  for (genvar s = 0; s < NSLOT; s++) begin : g_chk
    p_stalled_skip_r7: assert property (@(posedge clk) disable iff (rst)
      pk_vld[s] |-> (int'(pk_tid[s*TW +: TW]) < NTHR && ready[pk_tid[s*TW +: TW]]));
  end

  // single-thread policies grant at most one thread (R2)
  p_one_thread_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_i != 2'd2) |-> $onehot0(en));
endmodule

// File: tb/thread_issue_sel_test.sv
`timescale 1ns/1ps
module thread_issue_sel_test;
  localparam int REF = 5;
  logic clk = 1'b0, rst = 1'b1;
  logic [1:0]  mode_i = '0;
  logic [11:0] stall_len_i = '0;
  logic [23:0] req_cls_i = '0;
  logic [3:0]  slot_vld_o;
  logic [7:0]  slot_tid_o;
  logic        drain_o;

  thread_issue_sel uut (.clk(clk), .rst(rst), .mode_i(mode_i), .stall_len_i(stall_len_i),
    .req_cls_i(req_cls_i), .slot_vld_o(slot_vld_o), .slot_tid_o(slot_tid_o), .drain_o(drain_o));

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  int m_cur = 2, m_ref = 0;
  logic [3:0] e_vld;
  logic [7:0] e_tid;
  logic       e_drn;

  task automatic check(input string tag);
    checks++;
    if (slot_vld_o !== e_vld || slot_tid_o !== e_tid || drain_o !== e_drn) begin
      errors++;
      $display("FAIL %s: vld=%b tid=%h drain=%b expected vld=%b tid=%h drain=%b",
               tag, slot_vld_o, slot_tid_o, drain_o, e_vld, e_tid, e_drn);
    end
  endtask

  // reference: builds the expected grant map from the requirements
  task automatic model(input logic [1:0] m, input logic [11:0] st, input logic [23:0] w);
    logic [2:0] rdy, en;
    int nx, fnd, na, nm, nb;
    for (int t = 0; t < 3; t++) rdy[t] = (st[t*4 +: 4] == 0);
    fnd = 0; nx = 0;
    for (int i = 1; i <= 3; i++) if (!fnd && rdy[(m_cur+i)%3]) begin fnd = 1; nx = (m_cur+i)%3; end
    en = 0; e_drn = 0;
    if (m_ref > 0) begin e_drn = 1; m_ref--; end
    else if (m == 2'd1) begin
      if (rdy[m_cur]) en[m_cur] = 1;
      else if (st[m_cur*4 +: 4] > 2 && fnd) begin m_cur = nx; m_ref = REF-1; e_drn = 1; end
    end else if (m == 2'd2) en = rdy;
    else if (fnd) begin en[nx] = 1; m_cur = nx; end
    e_vld = 0; e_tid = 0; na = 0; nm = 0; nb = 0;
    for (int t = 0; t < 3; t++) begin
      bit blk;
      blk = !en[t];
      for (int k = 0; k < 4; k++) begin
        logic [1:0] c;
        c = w[(t*4+k)*2 +: 2];
        if (!blk) begin
          if (c == 1 && na < 2) begin e_vld[na] = 1; e_tid[na*2 +: 2] = 2'(t); na++; end
          else if (c == 2 && nm < 1) begin e_vld[2] = 1; e_tid[5:4] = 2'(t); nm++; end
          else if (c == 3 && nb < 1) begin e_vld[3] = 1; e_tid[7:6] = 2'(t); nb++; end
          else blk = 1;
        end
      end
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [11:0] st, input logic [23:0] w,
                      input string tag);
    mode_i = m; stall_len_i = st; req_cls_i = w;
    model(m, st, w);
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [23:0] mkw(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    return {c, b, a};
  endfunction

  initial begin
    #(200000*4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    e_vld = 0; e_tid = 0; e_drn = 0;
    check("R1 in reset");
    rst = 1'b0;
    // R1 / R2: first rotating picks 0,1,2,0
    for (int i = 0; i < 4; i++) step(2'd0, 12'h000, mkw(8'h01, 8'h01, 8'h01), "R2 rotate");
    // R2: stalled thread 1 skipped; mode 3 also rotates
    step(2'd3, 12'h030, mkw(8'h01, 8'h01, 8'h01), "R2 skip stalled");
    step(2'd0, 12'h030, mkw(8'h01, 8'h01, 8'h01), "R2 skip stalled");
    // R3: all stalled, pointer held
    step(2'd0, 12'h111, mkw(8'h01, 8'h01, 8'h01), "R3 all stalled");
    step(2'd0, 12'h000, mkw(8'h01, 8'h01, 8'h01), "R3 resume");
    // R4: stall-switch, issue then short stall
    step(2'd1, 12'h000, mkw(8'h95, 8'h95, 8'h95), "R4 issue");
    step(2'd1, 12'(2) << (m_cur*4), mkw(8'h95, 8'h95, 8'h95), "R4 short stall");
    step(2'd1, 12'h000, mkw(8'h95, 8'h95, 8'h95), "R4 same thread");
    // R5 / R9: long stall, mode flipped during drain
    step(2'd1, 12'(3) << (m_cur*4), mkw(8'h01, 8'h01, 8'h01), "R5 switch");
    for (int i = 0; i < REF; i++) step(2'd2, 12'h000, mkw(8'h95, 8'h0E, 8'h01), "R9 drain holds");
    // R5: long stall with no free thread, no switch
    step(2'd1, 12'h999, mkw(8'h01, 8'h01, 8'h01), "R5 no free thread");
    // R6 / R7 / R8: shared packing
    step(2'd2, 12'h000, mkw(8'h95, 8'h0E, 8'h01), "R6 R7 shared fill");
    step(2'd2, 12'h000, mkw(8'h04, 8'h0D, 8'h05), "R8 none stops");
    step(2'd2, 12'h004, mkw(8'h95, 8'h0E, 8'h01), "R7 stalled skipped");
    step(2'd2, 12'h000, mkw(8'hFF, 8'h07, 8'h0B), "R6 class limits");
    // R10: random mix
    for (int i = 0; i < 600; i++) begin
      logic [11:0] st;
      logic [1:0]  m;
      for (int t = 0; t < 3; t++) st[t*4 +: 4] = ($urandom % 10 < 6) ? 4'd0 : 4'(1 + $urandom % 5);
      m = 2'($urandom % 4);
      step(m, st, 24'($urandom), "R10 random");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule